// File: doc/BRIEF.md
# Mersenne Twister random word generator

This block produces a stream of 32-bit pseudo-random words following the standard 19937-bit Mersenne Twister recurrence (624 state words, lookahead distance 397, period 2^19937 - 1), followed by the usual tempering transform. The datapath uses only shifts, masks, XORs and one conditional constant XOR. There is no multiplier or divider. Once its two-stage pipeline has filled, it delivers one new word on every enabled clock.

The state vector lives in three memories of 624 entries each. One holds the top bit of every word. One holds the low 31 bits. One holds the full word and serves the lookahead read. Because of this split, each memory sees exactly one read and at most one write per cycle. The block contains no seeding arithmetic. A precomputed 624-word state image is written through a load port, one index/word pair per cycle. Generation then starts from state index 0.

Top module: `mt_prng`

## Requirements
- R1: While `rst` is high at a clock edge, `rnd_valid` goes low and `rnd` goes to zero.
- R2: In each cycle that `ld_en` is high, the word `ld_data` is written as state word number `ld_addr`, and the generator does not advance. `rnd_valid` is low after that edge and `rnd` holds its value. A load to an index of 624 or above changes no state.
- R3: After a load or a reset, the first enabled edge only primes the pipeline and leaves `rnd_valid` low. From the second enabled edge on, `rnd_valid` is high, and the first word corresponds to state index 0.
- R4: Each output word equals the tempered value of the new state word. The new word is mt[i] = mt[(i+397) mod 624] ^ (y>>1) ^ (y[0] ? 0x9908B0DF : 0), with y = (mt[i] & 0x80000000) | (mt[(i+1) mod 624] & 0x7FFFFFFF). Tempering applies y^=y>>11, y^=(y<<7)&0x9D2C5680, y^=(y<<15)&0xEFC60000 and y^=y>>18, in that order.
- R5: While `en` stays high with the pipeline primed, a new valid word appears on every clock.
- R6: An edge with `en` low freezes the state and `rnd`, and leaves `rnd_valid` low. When `en` returns, the sequence continues with no word skipped or repeated.
- R7: The state index wraps from 623 to 0, and words past the 624th use the state words written earlier in the run.
- R8: Starting from the image made by array seeding with key {0x123, 0x234, 0x345, 0x456}, the first word is 1067595299, and the first 1000 words match the software generator.
- R9: A load that starts while the generator is running stops it, and the next run restarts at index 0 of the newly loaded image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the generator by one word |
| ld_en | input | 1 | State load strobe, has priority over `en` |
| ld_addr | input | $clog2(N) | State word index to load |
| ld_data | input | 32 | State word to load |
| rnd | output | 32 | Tempered random word |
| rnd_valid | output | 1 | `rnd` holds a new word from this edge |

## Verification
The bench builds the block with its default sizes: N = 624 words and lookahead M = 397. At these sizes a software reference model of the full generator applies directly, and the known first output of the standard key-array seed can be checked. Runs of well over 624 words, including randomly paused ones, take the state index across its wrap point several times. The lookahead read then picks up words rewritten in the same run. Reloads in both ascending and descending index order reach the out-of-range load index as well as restarts from a mid-run load.

// File: rtl/mt_prng.sv
module mt_prng #(
  parameter int          N   = 624,
  parameter int          M   = 397,
  parameter logic [31:0] MAG = 32'h9908B0DF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 ld_en,
  input  logic [$clog2(N)-1:0] ld_addr,
  input  logic [31:0]          ld_data,
  output logic [31:0]          rnd,
  output logic                 rnd_valid
);
  localparam int AW = $clog2(N);

  logic        top_mem [N];
  logic [30:0] low_mem [N];
  logic [31:0] word_mem[N];

  logic [AW-1:0] idx, wr_idx, idx_nx, idx_ahead, wa;
  logic          top_q, primed, we;
  logic [30:0]   low_q;
  logic [31:0]   ahead_q, y, fresh, wd;

  function automatic logic [31:0] temper(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v >> 11);
    t = t ^ ((t << 7) & 32'h9D2C5680);
    t = t ^ ((t << 15) & 32'hEFC60000);
    return t ^ (t >> 18);
  endfunction

  wire run   = en & ~ld_en;
  wire ld_ok = ld_en && ({1'b0, ld_addr} < (AW+1)'(N));

  assign idx_nx    = (idx == AW'(N-1)) ? '0 : idx + 1'b1;
  assign idx_ahead = (idx >= AW'(N-M)) ? idx - AW'(N-M) : idx + AW'(M);

  assign y     = {top_q, low_q};
  assign fresh = ahead_q ^ {1'b0, y[31:1]} ^ (y[0] ? MAG : 32'h0);

  assign we = ld_ok | (run & primed);
  assign wa = ld_en ? ld_addr : wr_idx;
  assign wd = ld_en ? ld_data : fresh;

  always_ff @(posedge clk) begin
    if (we) begin
      top_mem[wa]  <= wd[31];
      low_mem[wa]  <= wd[30:0];
      word_mem[wa] <= wd;
    end
    if (run) begin
      top_q   <= top_mem[idx];
      low_q   <= low_mem[idx_nx];
      ahead_q <= word_mem[idx_ahead];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      wr_idx    <= '0;
      primed    <= 1'b0;
      rnd       <= '0;
      rnd_valid <= 1'b0;
    end else if (ld_en) begin
      idx       <= '0;
      primed    <= 1'b0;
      rnd_valid <= 1'b0;
    end else if (en) begin
      idx       <= idx_nx;
      wr_idx    <= idx;
      primed    <= 1'b1;
      rnd_valid <= primed;
      if (primed) rnd <= temper(fresh);
    end else begin
      rnd_valid <= 1'b0;
    end
  end

  p_valid_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |-> $past(en && !ld_en));
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (!en || ld_en) |=> $stable(rnd) && !rnd_valid);
  p_load_halts_r2: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> !rnd_valid);
  p_change_only_valid_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(rnd) |-> rnd_valid);
endmodule

// File: tb/test_mt_prng.sv
`timescale 1ns/1ps
module test_mt_prng;
  localparam int N = 624;
  localparam int M = 397;

  logic clk = 0, rst = 1, en = 0, ld_en = 0;
  logic [9:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] rnd;
  logic        rnd_valid;

  int total = 0, bad = 0;
  bit done = 0, primed = 0;
  logic [31:0] img [N];
  logic [31:0] ref_st [N];
  int ref_i;

  mt_prng i_mt_prng (.clk(clk), .rst(rst), .en(en), .ld_en(ld_en),
    .ld_addr(ld_addr), .ld_data(ld_data), .rnd(rnd), .rnd_valid(rnd_valid));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic seed_int(input logic [31:0] s);
    img[0] = s;
    for (int i = 1; i < N; i++)
      img[i] = 32'd1812433253 * (img[i-1] ^ (img[i-1] >> 30)) + 32'(i);
  endtask

  task automatic seed_key();
    logic [31:0] key [4];
    int i, j;
    key[0] = 32'h123; key[1] = 32'h234; key[2] = 32'h345; key[3] = 32'h456;
    seed_int(32'd19650218);
    i = 1; j = 0;
    for (int k = N; k > 0; k--) begin
      img[i] = (img[i] ^ ((img[i-1] ^ (img[i-1] >> 30)) * 32'd1664525)) + key[j] + 32'(j);
      i++; j++;
      if (i >= N) begin img[0] = img[N-1]; i = 1; end
      if (j >= 4) j = 0;
    end
    for (int k = N-1; k > 0; k--) begin
      img[i] = (img[i] ^ ((img[i-1] ^ (img[i-1] >> 30)) * 32'd1566083941)) - 32'(i);
      i++;
      if (i >= N) begin img[0] = img[N-1]; i = 1; end
    end
    img[0] = 32'h80000000;
  endtask

  task automatic model_next(output logic [31:0] w);
    logic [31:0] y, t;
    y = (ref_st[ref_i] & 32'h80000000) | (ref_st[(ref_i+1)%N] & 32'h7FFFFFFF);
    t = ref_st[(ref_i+M)%N] ^ (y >> 1) ^ (y[0] ? 32'h9908B0DF : 32'h0);
    ref_st[ref_i] = t;
    ref_i = (ref_i + 1) % N;
    t = t ^ (t >> 11);
    t = t ^ ((t << 7) & 32'h9D2C5680);
    t = t ^ ((t << 15) & 32'hEFC60000);
    w = t ^ (t >> 18);
  endtask

  task automatic load_image(input bit descending);
    logic [31:0] hold;
    for (int a = 0; a < N; a++) begin
      hold = rnd;
      ld_en = 1; en = 1'($urandom);
      ld_addr = 10'(descending ? N-1-a : a);
      ld_data = img[descending ? N-1-a : a];
      tick();
      chk(!rnd_valid && rnd == hold, "R2 load halts generator", {31'b0, rnd_valid}, hold);
    end
    ld_addr = 10'd700; ld_data = 32'hDEADBEEF; tick();
    ld_en = 0; en = 0;
    for (int a = 0; a < N; a++) ref_st[a] = img[a];
    ref_i = 0; primed = 0;
  endtask

  task automatic cycle(input bit e, input string tag, output bit got, output logic [31:0] w);
    bit exp_v;
    logic [31:0] prev;
    exp_v = e && primed;
    prev = rnd; en = e;
    tick();
    if (e) primed = 1;
    got = exp_v; w = '0;
    chk(rnd_valid == exp_v, {tag, " valid"}, {31'b0, rnd_valid}, {31'b0, exp_v});
    if (exp_v) begin
      model_next(w);
      chk(rnd == w, {tag, " word"}, rnd, w);
    end else
      chk(rnd == prev, "R6 output frozen", rnd, prev);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit got;
    logic [31:0] w;
    int n;
    void'($urandom(32'd1234));
    tick(); tick(); tick();
    chk(!rnd_valid && rnd == 0, "R1 reset state", rnd, 32'h0);
    rst = 0;

    seed_key();
    load_image(0);
    cycle(1, "R3 priming edge", got, w);
    chk(!got, "R3 first edge primes only", {31'b0, rnd_valid}, 32'h0);
    cycle(1, "R8 first word", got, w);
    chk(rnd == 32'd1067595299, "R8 known first word", rnd, 32'd1067595299);
    for (int k = 1; k < 1000; k++) cycle(1, "R5 R7 R8 continuous", got, w);

    for (int k = 0; k < 1500; k++) cycle(($urandom % 4) != 0, "R6 R7 paused run", got, w);

    ld_en = 1; en = 1; ld_addr = 10'd900; ld_data = 32'h0;
    w = rnd; tick();
    chk(!rnd_valid && rnd == w, "R9 load stops run", rnd, w);
    ld_en = 0;
    seed_int(32'd5489);
    load_image(1);
    cycle(0, "R6 idle after load", got, w);
    cycle(1, "R3 priming edge", got, w);
    cycle(1, "R9 restart word", got, w);
    chk(rnd == 32'd3499211612, "R9 R4 restart from new image", rnd, 32'd3499211612);
    n = 0;
    for (int k = 0; k < 800; k++) begin
      cycle(($urandom % 8) != 0, "R4 R7 second image", got, w);
      if (got) n++;
    end
    chk(n > 624, "R7 wrap reached", 32'(n), 32'd625);

    rst = 1; tick();
    chk(!rnd_valid && rnd == 0, "R1 reset mid-run", rnd, 32'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule